// File: doc/BRIEF.md
# PCM Short-Frame Serial Port

This block moves 8-bit PCM samples across a pair of serial links that use short frame sync pulses. The links are framed by bit clocks and one-bit-period sync pulses. All logic runs on one system clock. The bit clocks, frame syncs and serial input are sampled on that clock, and their edges are detected from the samples. The system clock must therefore be several times faster than either bit clock.

On the transmit side, a sync seen high at a falling bit-clock edge starts a new encode cycle. At that moment the parallel word present on `tx_word_i` is captured for the next frame. The word captured at the previous sync is loaded for sending. The output enable opens on the next rising edge, and the word leaves MSB first, one bit per rising edge. A pull-down enable for the open-drain slot indicator is asserted for the whole slot. The first falling edge after the last bit closes the output. There is no earlier word after reset, so the first frame sends nothing.

On the receive side, a sync seen high at a falling receive bit-clock edge arms the receiver. The next eight falling edges capture the word MSB first. After the last bit the word is presented together with a one-cycle valid strobe. Short-frame timing is the only framing this block supports.

Top module: `pcm_sf_port`

## Requirements
- R1: After reset, `tx_oe_o`, `tx_slot_pd_o`, `tx_sd_o`, `rx_valid_o` and `rx_word_o` are all 0.
- R2: When `tx_fs_i` is high at a falling `tx_bclk_i` edge, the output stays disabled until the next rising edge. That rising edge sets `tx_oe_o` and drives the word's MSB (bit 7) on `tx_sd_o`.
- R3: The next W-1 rising edges shift out bits 6 down to 0 in that order. `tx_sd_o` holds its value across falling edges during the slot.
- R4: The first falling edge after the last bit clears `tx_oe_o`. `tx_sd_o` is 0 whenever `tx_oe_o` is 0.
- R5: The word sent in a frame is the `tx_word_i` value sampled at the previous sync. Changes to `tx_word_i` after a sync have no effect on the frame that sync starts.
- R6: The first transmit sync after reset has no earlier word, so `tx_oe_o` stays 0 for that whole frame.
- R7: `tx_slot_pd_o` (1 = pull the slot indicator low) is asserted exactly while the data output is enabled.
- R8: When `rx_fs_i` is high at a falling `rx_bclk_i` edge, the next W falling edges sample `rx_sd_i` MSB first. After the W-th sample, `rx_word_o` is updated and `rx_valid_o` pulses for exactly one clock. `rx_word_o` changes at no other time.
- R9: Frames may run back to back. A sync on the same falling edge that closes the previous slot (transmit) or captures its last bit (receive) both ends the old frame and starts the new one.
- R10: A receive sync that arrives before a word is complete restarts the reception. The partial word is discarded and no valid strobe is raised for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than both bit clocks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_bclk_i | input | 1 | Transmit bit clock |
| tx_fs_i | input | 1 | Transmit short frame sync |
| tx_word_i | input | W | Parallel word for transmission |
| tx_sd_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Output enable for `tx_sd_o` (1 = driven) |
| tx_slot_pd_o | output | 1 | Slot indicator pull-down enable (1 = pull low) |
| rx_bclk_i | input | 1 | Receive bit clock |
| rx_fs_i | input | 1 | Receive short frame sync |
| rx_sd_i | input | 1 | Serial receive data |
| rx_word_o | output | W | Last complete received word |
| rx_valid_o | output | 1 | One-cycle strobe for a new `rx_word_o` |

## Verification
The bench sweeps all 256 word values through both directions and mixes isolated frames with back-to-back frames. In the back-to-back case the closing falling edge carries the next sync.

- A design that opened the output on the sync's falling edge, rather than the following rising edge, would show `tx_oe_o` high during the sync half-period.
- A design that sent the current word instead of the earlier one would show its data one frame too early.
- A design that sampled `tx_word_i` late would pick up the value the bench scrambles just after each sync.
- On the receive side, a resync after three bits checks that a partial word is dropped rather than delivered.
- The back-to-back frames check that the final bit is still captured when the next sync shares its edge.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int PCM_WORD_W = 8;
  localparam int PCM_SYNC_STAGES = 1;
endpackage

// File: rtl/pcm_edge_sync.sv
// Samples a bit clock plus companion lines; index 0 of raw_i is the clock.
module pcm_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:1] dat_o,
  output logic         rise_o,
  output logic         fall_o
);
  logic [N-1:0] smp_q;
  logic         clk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q      <= '0;
      clk_prev_q <= 1'b0;
    end else begin
      smp_q      <= raw_i;
      clk_prev_q <= smp_q[0];
    end
  end

  assign dat_o  = smp_q[N-1:1];
  assign rise_o = smp_q[0] & ~clk_prev_q;
  assign fall_o = ~smp_q[0] & clk_prev_q;
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
  parameter int W = pcm_pkg::PCM_WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         fs_i,
  input  logic [W-1:0] word_i,
  output logic         sd_o,
  output logic         oe_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  hold_q, shf_q;
  logic          hold_ok_q, go_q, pend_q, oe_q, sd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= '0;
      shf_q     <= '0;
      hold_ok_q <= 1'b0;
      go_q      <= 1'b0;
      pend_q    <= 1'b0;
      oe_q      <= 1'b0;
      sd_q      <= 1'b0;
      cnt_q     <= '0;
    end else if (fall_i) begin
      if (oe_q && cnt_q == CW'(W)) begin
        oe_q <= 1'b0;
        sd_q <= 1'b0;
      end
      if (fs_i) begin
        // previous-cycle word goes out, current word waits a frame
        shf_q     <= hold_q;
        go_q      <= hold_ok_q;
        hold_q    <= word_i;
        hold_ok_q <= 1'b1;
        pend_q    <= 1'b1;
        oe_q      <= 1'b0;
        sd_q      <= 1'b0;
      end
    end else if (rise_i) begin
      if (pend_q) begin
        pend_q <= 1'b0;
        if (go_q) begin
          oe_q  <= 1'b1;
          sd_q  <= shf_q[W-1];
          shf_q <= shf_q << 1;
          cnt_q <= CW'(1);
        end
      end else if (oe_q && cnt_q < CW'(W)) begin
        sd_q  <= shf_q[W-1];
        shf_q <= shf_q << 1;
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign sd_o = sd_q;
  assign oe_o = oe_q;
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
  parameter int W = pcm_pkg::PCM_WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fall_i,
  input  logic         fs_i,
  input  logic         sd_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  localparam int CW = $clog2(W);

  logic [W-2:0]  shf_q;
  logic [W-1:0]  word_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shf_q   <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (fall_i) begin
        if (armed_q) begin
          shf_q <= {shf_q[W-3:0], sd_i};
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(W - 1)) begin
            word_q  <= {shf_q, sd_i};
            valid_q <= 1'b1;
            armed_q <= 1'b0;
          end
        end
        // sync wins: restarts a partial word, or follows a finished one
        if (fs_i) begin
          armed_q <= 1'b1;
          cnt_q   <= '0;
        end
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/pcm_sf_port.sv
module pcm_sf_port #(
  parameter int WORD_W = pcm_pkg::PCM_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_bclk_i,
  input  logic              tx_fs_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_sd_o,
  output logic              tx_oe_o,
  output logic              tx_slot_pd_o,
  input  logic              rx_bclk_i,
  input  logic              rx_fs_i,
  input  logic              rx_sd_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);
  logic       tx_rise_w, tx_fall_w, tx_fs_w;
  logic       rx_rise_w, rx_fall_w;
  logic [2:1] rx_dat_w;

  pcm_edge_sync #(.N(2)) u_tx_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({tx_fs_i, tx_bclk_i}),
    .dat_o  (tx_fs_w),
    .rise_o (tx_rise_w),
    .fall_o (tx_fall_w)
  );

  pcm_edge_sync #(.N(3)) u_rx_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({rx_sd_i, rx_fs_i, rx_bclk_i}),
    .dat_o  (rx_dat_w),
    .rise_o (rx_rise_w),
    .fall_o (rx_fall_w)
  );

  pcm_tx_ser #(.W(WORD_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (tx_rise_w),
    .fall_i (tx_fall_w),
    .fs_i   (tx_fs_w),
    .word_i (tx_word_i),
    .sd_o   (tx_sd_o),
    .oe_o   (tx_oe_o)
  );

  pcm_rx_deser #(.W(WORD_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (rx_fall_w & ~rx_rise_w),
    .fs_i    (rx_dat_w[1]),
    .sd_i    (rx_dat_w[2]),
    .word_o  (rx_word_o),
    .valid_o (rx_valid_o)
  );

  // open-drain slot indicator modelled as active-high pull-down enable
  assign tx_slot_pd_o = tx_oe_o;
endmodule

// File: rtl/pcm_sf_port_chk.sv
module pcm_sf_port_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tx_rise,
  input logic         tx_fall,
  input logic         tx_oe,
  input logic         tx_sd,
  input logic         rx_valid,
  input logic [W-1:0] rx_word
);
  a_r2_oe_opens_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_oe) |-> $past(tx_rise));

  a_r4_oe_closes_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_oe) |-> $past(tx_fall));

  a_r4_idle_data_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_oe |-> !tx_sd);

  a_r3_data_moves_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_oe && $past(tx_oe) && !$stable(tx_sd)) |-> $past(tx_rise));

  a_r8_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid |=> !rx_valid);

  a_r8_word_only_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_word) |-> rx_valid);
endmodule

bind pcm_sf_port pcm_sf_port_chk #(.W(WORD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tx_rise  (tx_rise_w),
  .tx_fall  (tx_fall_w),
  .tx_oe    (tx_oe_o),
  .tx_sd    (tx_sd_o),
  .rx_valid (rx_valid_o),
  .rx_word  (rx_word_o)
);

// File: tb/tb_pcm_sf_port.sv
`timescale 1ns/1ps
module tb_pcm_sf_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tx_bclk = 1'b1, tx_fs = 1'b0, rx_bclk = 1'b1, rx_fs = 1'b0, rx_sd = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic         tx_sd, tx_oe, tx_pd, rx_valid;
  logic [W-1:0] rx_word;

  int n_tests = 0, n_fail = 0;
  int vcnt = 0, vbase = 0;
  bit done = 0;

  logic [W-1:0] prev = '0, exp_rx = '0;
  bit have_prev = 0, rx_pend = 0;

  always #5 clk = ~clk;

  pcm_sf_port #(.WORD_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_bclk_i(tx_bclk), .tx_fs_i(tx_fs), .tx_word_i(tx_word),
    .tx_sd_o(tx_sd), .tx_oe_o(tx_oe), .tx_slot_pd_o(tx_pd),
    .rx_bclk_i(rx_bclk), .rx_fs_i(rx_fs), .rx_sd_i(rx_sd),
    .rx_word_o(rx_word), .rx_valid_o(rx_valid)
  );

  always @(posedge clk) if (rst_n && rx_valid) vcnt <= vcnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fall_edge();
    @(negedge clk);
    tx_bclk = 1'b0; rx_bclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic rise_edge();
    @(negedge clk);
    tx_bclk = 1'b1; rx_bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // checks after a falling edge that ends a slot
  task automatic close_check();
    chk(tx_oe == 1'b0, "R4 oe closed", tx_oe, 0);
    chk(tx_sd == 1'b0, "R4 sd idle", tx_sd, 0);
    chk(tx_pd == 1'b0, "R7 pd released", tx_pd, 0);
    if (rx_pend) begin
      chk(vcnt - vbase == 1, "R8 one valid", vcnt - vbase, 1);
      chk(rx_word == exp_rx, "R8/R9 rx word", rx_word, exp_rx);
    end else begin
      chk(vcnt - vbase == 0, "R10 no valid", vcnt - vbase, 0);
    end
    rx_pend = 0;
    vbase = vcnt;
  endtask

  task automatic frame(input logic [W-1:0] w, input logic [W-1:0] rw);
    logic [W-1:0] cur;
    bit cur_ok;
    cur = prev; cur_ok = have_prev;
    tx_fs = 1'b1; rx_fs = 1'b1; tx_word = w;
    fall_edge();
    close_check();
    chk(tx_oe == 1'b0, "R2 no oe before rise", tx_oe, 0);
    tx_fs = 1'b0; rx_fs = 1'b0; rx_sd = rw[W-1];
    rise_edge();
    tx_word = ~w;
    chk(tx_oe == cur_ok, "R2/R6 oe at first rise", tx_oe, cur_ok);
    chk(tx_pd == tx_oe, "R7 pd tracks slot", tx_pd, tx_oe);
    if (cur_ok) chk(tx_sd == cur[W-1], "R2/R5 msb", tx_sd, cur[W-1]);
    for (int i = 1; i < W; i++) begin
      fall_edge();
      chk(tx_oe == cur_ok, "R3/R6 oe in slot", tx_oe, cur_ok);
      if (cur_ok) chk(tx_sd == cur[W-i], "R3 hold over fall", tx_sd, cur[W-i]);
      chk(vcnt - vbase == 0, "R8 no early valid", vcnt - vbase, 0);
      rx_sd = rw[W-1-i];
      rise_edge();
      if (cur_ok) chk(tx_sd == cur[W-1-i], "R3/R5 bit", tx_sd, cur[W-1-i]);
    end
    prev = w; have_prev = 1; rx_pend = 1; exp_rx = rw;
  endtask

  task automatic close_frame();
    tx_fs = 1'b0; rx_fs = 1'b0;
    fall_edge();
    close_check();
    rise_edge();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_oe == 0 && tx_pd == 0 && tx_sd == 0, "R1 tx reset", {tx_oe, tx_pd, tx_sd}, 0);
    chk(rx_valid == 0 && rx_word == 0, "R1 rx reset", rx_word, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_oe == 0 && rx_valid == 0, "R1 after release", {tx_oe, rx_valid}, 0);
    vbase = vcnt;

    frame(8'hA5, 8'h3C);     // R6 first frame silent
    close_frame();
    for (int i = 0; i < 256; i++) begin
      frame(W'(i), W'(i) ^ W'(8'h5A) ^ W'(i << 3));
      if (i % 4 == 3) close_frame();   // otherwise back to back (R9)
    end
    close_frame();

    // R10: receive resync after three bits
    rx_fs = 1'b1;
    fall_edge();
    rx_fs = 1'b0; rx_sd = 1'b1;
    rise_edge();
    for (int i = 0; i < 3; i++) begin
      fall_edge();
      rx_sd = ~rx_sd;
      rise_edge();
    end
    rx_pend = 0;
    frame(8'h11, 8'hC3);
    close_frame();
    chk(rx_word == 8'hC3, "R10 restarted word", rx_word, 8'hC3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule